// File: doc/BRIEF.md
# Packet Payload XOR Cipher Stage

This stage sits in a 64-bit packet pipeline. Words arrive on a data bus with an 8-bit control field and a write strobe. They go through a small fall-through FIFO and leave on an identical bus. Only the payload that follows an option-free IPv4 header is changed: every payload byte is XORed with a byte of a 32-bit key. All other words and bytes pass through bit for bit. XOR is its own inverse, so a second pass through the stage with the same key gives back the original frame.

Each packet starts with one or more module header words, which carry a nonzero control field. The frame itself follows, with zero control on every word except the last. The Ethernet and IPv4 headers together take 34 bytes. The payload therefore starts two bytes into the fifth frame word, and that word is split into clear lanes and ciphered lanes. The key is sampled once per packet, so software may rewrite it at any time without tearing a packet.

Top module: `payloadXorStage`

## Requirements
- R1: Passing a frame through the stage twice with the same key returns the original words and control values.
- R2: Words with nonzero control that come before a frame's first zero-control word are module headers. They leave unchanged and do not count toward the byte offset.
- R3: Frame bytes 1 to 34 leave unchanged. Byte 1 is in lane 7 (bits 63:56) of the first frame word, and later bytes fill lanes in falling order. Frame words 1 to 4 are all clear, and so are lanes 7 and 6 of word 5.
- R4: Every byte from byte 35 onward is XORed with the key byte for its lane. Lane i uses key bits [8*(i mod 4)+7 : 8*(i mod 4)].
- R5: A frame has at least two words. Its last word has a nonzero control value in which bit i marks lane i as valid. Only valid payload lanes are XORed, and the stage then returns to skipping module headers.
- R6: The key is captured when the first module header of a packet leaves the FIFO. A change to the key input during the packet does not affect that packet.
- R7: outWr is high only in the cycle after a cycle in which outRdy was high.
- R8: Under any pattern of outRdy, every accepted word leaves exactly once, in order, with its control field unchanged.
- R9: inRdy is low while the FIFO holds DEPTH words. Every word written while inRdy is high is accepted.
- R10: After reset, outWr is low and inRdy is high.
- R11: A frame that ends before byte 35 leaves fully unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 64 | Incoming data word |
| inCtrl | input | 8 | Incoming control field |
| inWr | input | 1 | Write strobe for the incoming word |
| inRdy | output | 1 | FIFO has room for one more word |
| outData | output | 64 | Outgoing data word |
| outCtrl | output | 8 | Outgoing control field |
| outWr | output | 1 | Write strobe for the outgoing word |
| outRdy | input | 1 | Downstream can take a word |
| keyIn | input | 32 | Key value from the software register |

## Verification
Frames of random length and random header count go through once with random backpressure. Every word is compared with a model that picks the clear and ciphered lanes from the byte index. This separates an error in header skipping from an error at the split word or in the valid-lane mask. Each ciphertext is then fed back and must match the original, which tests that XOR undoes itself. Directed frames cover a frame that ends inside the header region, one that ends one byte into the payload, a key change in the middle of a packet, and a stall long enough to fill the FIFO.

// File: rtl/xorStagePkg.sv
package xorStagePkg;
  typedef enum logic [2:0] {
    S_INIT,
    S_SKIP,
    S_PASS,
    S_BOUND,
    S_PAY
  } xorState_t;

  typedef struct packed {
    logic pop;
    logic latchKey;
  } xorStrobe_t;
endpackage

// File: rtl/xorStageFifo.sv
module xorStageFifo #(
  parameter int WIDTH = 72,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] wrData,
  input  logic             wrEn,
  output logic             wrRdy,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doWr, doRd;

  assign wrRdy   = (count != CNT_W'(DEPTH));
  assign rdValid = (count != '0);
  assign rdData  = mem[rdPtr];
  assign doWr    = wrEn && wrRdy;
  assign doRd    = rdEn && rdValid;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= nextPtr(wrPtr);
      if (doRd) rdPtr <= nextPtr(rdPtr);
      if (doWr && !doRd) count <= count + 1'b1;
      else if (doRd && !doWr) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end
endmodule

// File: rtl/xorStageCtrl.sv
module xorStageCtrl
  import xorStagePkg::*;
#(
  parameter int LANES     = 8,
  parameter int CTRL_W    = 8,
  parameter int HDR_BYTES = 34
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              headValid,
  input  logic [CTRL_W-1:0] headCtrl,
  input  logic              outRdy,
  output xorStrobe_t        strb,
  output logic [LANES-1:0]  xorMask
);
  localparam int CLEAR_WORDS = HDR_BYTES / LANES;
  localparam int CLEAR_LANES = HDR_BYTES % LANES;
  localparam int CNT_W       = (CLEAR_WORDS > 1) ? $clog2(CLEAR_WORDS) : 1;
  localparam logic [LANES-1:0] BOUND_MASK = {LANES{1'b1}} >> CLEAR_LANES;

  xorState_t        state;
  logic             sawHdr;
  logic [CNT_W-1:0] wordCnt;
  logic             lastWord;
  logic [LANES-1:0] laneValid;

  assign lastWord  = |headCtrl;
  assign laneValid = lastWord ? headCtrl[LANES-1:0] : {LANES{1'b1}};

  always_comb begin
    strb.pop      = headValid && outRdy && (state != S_INIT);
    strb.latchKey = strb.pop && (state == S_SKIP) && lastWord && !sawHdr;
    case (state)
      S_BOUND: xorMask = BOUND_MASK & laneValid;
      S_PAY:   xorMask = laneValid;
      default: xorMask = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_INIT;
      sawHdr  <= 1'b0;
      wordCnt <= '0;
    end else if (state == S_INIT) begin
      state <= S_SKIP;
    end else if (strb.pop) begin
      case (state)
        S_SKIP: begin
          if (lastWord) begin
            sawHdr <= 1'b1;
          end else begin
            sawHdr  <= 1'b0;
            wordCnt <= CNT_W'(1);
            state   <= (CLEAR_WORDS <= 1) ? S_BOUND : S_PASS;
          end
        end
        S_PASS: begin
          if (lastWord) state <= S_SKIP;
          else begin
            wordCnt <= wordCnt + 1'b1;
            if (wordCnt == CNT_W'(CLEAR_WORDS - 1)) state <= S_BOUND;
          end
        end
        S_BOUND: state <= lastWord ? S_SKIP : S_PAY;
        S_PAY:   if (lastWord) state <= S_SKIP;
        default: state <= S_SKIP;
      endcase
    end
  end
endmodule

// File: rtl/xorStageDatapath.sv
module xorStageDatapath
  import xorStagePkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CTRL_W = 8,
  parameter int KEY_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  xorStrobe_t          strb,
  input  logic [DATA_W/8-1:0] xorMask,
  input  logic [DATA_W-1:0]   headData,
  input  logic [CTRL_W-1:0]   headCtrl,
  input  logic [KEY_W-1:0]    keyIn,
  output logic [DATA_W-1:0]   outData,
  output logic [CTRL_W-1:0]   outCtrl,
  output logic                outWr,
  output logic [KEY_W-1:0]    keyHeld
);
  localparam int LANES = DATA_W / 8;
  localparam int REPS  = DATA_W / KEY_W;

  logic [DATA_W-1:0] keyWide, bitMask;

  for (genvar r = 0; r < REPS; r++) begin : gKeyRep
    assign keyWide[r*KEY_W +: KEY_W] = keyHeld;
  end

  for (genvar l = 0; l < LANES; l++) begin : gLaneMask
    assign bitMask[l*8 +: 8] = {8{xorMask[l]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyHeld <= '0;
      outWr   <= 1'b0;
      outData <= '0;
      outCtrl <= '0;
    end else begin
      if (strb.latchKey) keyHeld <= keyIn;
      outWr <= strb.pop;
      if (strb.pop) begin
        outData <= headData ^ (keyWide & bitMask);
        outCtrl <= headCtrl;
      end
    end
  end
endmodule

// File: rtl/payloadXorStage.sv
module payloadXorStage
  import xorStagePkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int CTRL_W    = 8,
  parameter int KEY_W     = 32,
  parameter int DEPTH     = 4,
  parameter int HDR_BYTES = 34
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic [CTRL_W-1:0] inCtrl,
  input  logic              inWr,
  output logic              inRdy,
  output logic [DATA_W-1:0] outData,
  output logic [CTRL_W-1:0] outCtrl,
  output logic              outWr,
  input  logic              outRdy,
  input  logic [KEY_W-1:0]  keyIn
);
  localparam int LANES  = DATA_W / 8;
  localparam int WORD_W = DATA_W + CTRL_W;

  xorStrobe_t        strb;
  logic [WORD_W-1:0] headWord;
  logic              headValid;
  logic [DATA_W-1:0] headData;
  logic [CTRL_W-1:0] headCtrl;
  logic [LANES-1:0]  xorMask;
  logic [KEY_W-1:0]  keyHeld;

  assign headData = headWord[DATA_W-1:0];
  assign headCtrl = headWord[WORD_W-1:DATA_W];

  xorStageFifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) uFifo (
    .clk(clk), .rstN(rstN),
    .wrData({inCtrl, inData}), .wrEn(inWr), .wrRdy(inRdy),
    .rdEn(strb.pop), .rdData(headWord), .rdValid(headValid)
  );

  xorStageCtrl #(.LANES(LANES), .CTRL_W(CTRL_W), .HDR_BYTES(HDR_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .headValid(headValid), .headCtrl(headCtrl),
    .outRdy(outRdy), .strb(strb), .xorMask(xorMask)
  );

  xorStageDatapath #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .KEY_W(KEY_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .xorMask(xorMask),
    .headData(headData), .headCtrl(headCtrl), .keyIn(keyIn),
    .outData(outData), .outCtrl(outCtrl), .outWr(outWr), .keyHeld(keyHeld)
  );
endmodule

// File: rtl/payloadXorStageChk.sv
module payloadXorStageChk #(
  parameter int DATA_W = 64,
  parameter int CTRL_W = 8,
  parameter int KEY_W  = 32,
  parameter int LANES  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inWr,
  input logic              inRdy,
  input logic              outWr,
  input logic              outRdy,
  input logic [DATA_W-1:0] outData,
  input logic [CTRL_W-1:0] outCtrl,
  input logic              pop,
  input logic              latchKey,
  input logic [DATA_W-1:0] headData,
  input logic [CTRL_W-1:0] headCtrl,
  input logic [LANES-1:0]  xorMask,
  input logic [KEY_W-1:0]  keyHeld
);
  a_r7_wr_after_rdy: assert property (@(posedge clk) disable iff (!rstN)
    outWr |-> $past(outRdy));

  a_r8_ctrl_kept: assert property (@(posedge clk) disable iff (!rstN)
    pop |=> (outWr && outCtrl == $past(headCtrl)));

  a_r3_clear_word: assert property (@(posedge clk) disable iff (!rstN)
    (pop && xorMask == '0) |=> (outData == $past(headData)));

  a_r6_key_hold: assert property (@(posedge clk) disable iff (!rstN)
    !latchKey |=> $stable(keyHeld));

  a_r2_latch_on_hdr: assert property (@(posedge clk) disable iff (!rstN)
    latchKey |-> (pop && headCtrl != '0 && xorMask == '0));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    inWr |-> inRdy);
endmodule

bind payloadXorStage payloadXorStageChk #(
  .DATA_W(DATA_W), .CTRL_W(CTRL_W), .KEY_W(KEY_W), .LANES(LANES)
) uChk (
  .clk(clk), .rstN(rstN), .inWr(inWr), .inRdy(inRdy), .outWr(outWr),
  .outRdy(outRdy), .outData(outData), .outCtrl(outCtrl), .pop(strb.pop),
  .latchKey(strb.latchKey), .headData(headData), .headCtrl(headCtrl),
  .xorMask(xorMask), .keyHeld(keyHeld)
);

// File: tb/sim_payloadXorStage.sv
module sim_payloadXorStage;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [63:0] inData = '0;
  logic [7:0]  inCtrl = '0;
  logic inWr = 1'b0;
  logic inRdy;
  logic [63:0] outData;
  logic [7:0]  outCtrl;
  logic outWr;
  logic outRdy = 1'b0;
  logic [31:0] keyIn = '0;

  int checks = 0, errors = 0;
  int outCount = 0, wrCount = 0, rdyPct = 7;
  bit holdRdy = 1'b0, finished = 1'b0, lastRdy = 1'b0;

  logic [71:0] expQ[$];
  string       tagQ[$];
  logic [63:0] pkD[$], encD[$];
  logic [7:0]  pkC[$];
  int          pkIdx[$];

  always #5 clk = ~clk;

  payloadXorStage u0 (
    .clk(clk), .rstN(rstN), .inData(inData), .inCtrl(inCtrl), .inWr(inWr),
    .inRdy(inRdy), .outData(outData), .outCtrl(outCtrl), .outWr(outWr),
    .outRdy(outRdy), .keyIn(keyIn)
  );

  task automatic check(input bit ok, input string tag, input logic [71:0] act,
                       input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor and downstream ready, one process so ordering is fixed
  always @(negedge clk) begin
    if (rstN && outWr) begin
      check(lastRdy, "R7", {71'd0, lastRdy}, 72'd1);
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected word", {outCtrl, outData}, '0);
      end else begin
        logic [71:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({outCtrl, outData} === e, t, {outCtrl, outData}, e);
      end
      outCount++;
    end
    outRdy  = holdRdy ? 1'b0 : (($urandom % 10) < rdyPct);
    lastRdy = outRdy;
  end

  function automatic logic [63:0] expWord(input logic [63:0] d, input logic [7:0] c,
                                          input int idx, input logic [31:0] key);
    logic [63:0] r;
    logic [7:0]  valid;
    r = d;
    if (idx < 0) return r;
    valid = (c != 0) ? c : 8'hFF;
    for (int lane = 0; lane < 8; lane++) begin
      int b;
      b = idx * 8 + (7 - lane);
      if (valid[lane] && b >= 34)
        r[lane*8 +: 8] = d[lane*8 +: 8] ^ key[(lane % 4)*8 +: 8];
    end
    return r;
  endfunction

  task automatic makePkt(input int nh, input int len, input logic [31:0] key);
    int nw, nl;
    pkD.delete(); pkC.delete(); pkIdx.delete(); encD.delete();
    for (int h = 0; h < nh; h++) begin
      pkD.push_back({$urandom, $urandom});
      pkC.push_back(8'(($urandom % 255) + 1));
      pkIdx.push_back(-1);
    end
    nw = (len + 7) / 8;
    nl = len - 8 * (nw - 1);
    for (int w = 0; w < nw; w++) begin
      pkD.push_back({$urandom, $urandom});
      pkC.push_back((w == nw - 1) ? 8'(8'hFF << (8 - nl)) : 8'h00);
      pkIdx.push_back(w);
    end
    for (int i = 0; i < pkD.size(); i++)
      encD.push_back(expWord(pkD[i], pkC[i], pkIdx[i], key));
  endtask

  function automatic string tagFor(input int i);
    string t;
    if (pkIdx[i] < 0) return "R2";
    if (pkIdx[i] < 4) t = "R3";
    else if (pkIdx[i] == 4) t = "R3,R4";
    else t = "R4";
    if (pkC[i] != 0) t = {t, ",R5"};
    return t;
  endfunction

  task automatic pushExp(input bit useEnc, input string over);
    for (int i = 0; i < pkD.size(); i++) begin
      expQ.push_back({pkC[i], useEnc ? encD[i] : pkD[i]});
      tagQ.push_back(over != "" ? over : tagFor(i));
    end
  endtask

  task automatic drive(input int from, input int upto, input bit useEnc);
    for (int i = from; i < upto; i++) begin
      @(negedge clk);
      inWr = 1'b0;
      while (($urandom % 4) == 0) @(negedge clk);
      while (!inRdy) @(negedge clk);
      inWr = 1'b1;
      inData = useEnc ? encD[i] : pkD[i];
      inCtrl = pkC[i];
      wrCount++;
    end
    @(negedge clk);
    inWr = 1'b0;
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic roundTrip(input int nh, input int len, input logic [31:0] key,
                           input string over);
    waitDrain();
    keyIn = key;
    makePkt(nh, len, key);
    pushExp(1'b1, over);
    drive(0, pkD.size(), 1'b0);
    waitDrain();
    pushExp(1'b0, "R1");
    drive(0, pkD.size(), 1'b1);
    waitDrain();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outWr == 1'b0, "R10 outWr", {71'd0, outWr}, 72'd0);
    check(inRdy == 1'b1, "R10 inRdy", {71'd0, inRdy}, 72'd1);

    // directed frames
    roundTrip(1, 60, 32'hA5C3_0F96, "");
    roundTrip(2, 20, 32'h1122_3344, "R11");
    roundTrip(1, 35, 32'hDEAD_BEEF, "");
    roundTrip(3, 41, 32'h0102_0408, "");

    // R9: FIFO fills while downstream is stalled
    waitDrain();
    holdRdy = 1'b1;
    @(negedge clk);
    keyIn = 32'h7777_1357;
    makePkt(1, 64, keyIn);
    pushExp(1'b1, "R9");
    begin
      int wr0, out0;
      wr0 = wrCount;
      out0 = outCount;
      fork drive(0, pkD.size(), 1'b0); join_none
      repeat (20) @(negedge clk);
      check(inRdy == 1'b0, "R9 full", {71'd0, inRdy}, 72'd0);
      check(wrCount - wr0 == 4, "R9 accepted", 72'(wrCount - wr0), 72'd4);
      check(outCount == out0, "R7 stalled", 72'(outCount), 72'(out0));
      holdRdy = 1'b0;
      wait fork;
    end
    waitDrain();

    // R6: key changes after the first header has been taken
    begin
      int base;
      keyIn = 32'hCAFE_F00D;
      makePkt(2, 90, 32'hCAFE_F00D);
      pushExp(1'b1, "R6");
      base = outCount;
      drive(0, 2, 1'b0);
      wait (outCount >= base + 1);
      keyIn = 32'h0BAD_0BAD;
      drive(2, pkD.size(), 1'b0);
      waitDrain();
    end
    roundTrip(1, 70, 32'h0BAD_0BAD, "");

    // random frames under random backpressure
    for (int p = 0; p < 25; p++) begin
      rdyPct = 3 + ($urandom % 8);
      roundTrip(1 + ($urandom % 3), 9 + ($urandom % 190), $urandom, "");
    end
    rdyPct = 10;
    waitDrain();

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired, pending=%0d expected=0", expQ.size());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule